// File: doc/BRIEF.md
# Asynchronous Byte-Loading Peripheral Port

This block lets a host processor push configuration bytes into a device through a small asynchronous port. The host has two chip selects (one active low, one active high), a write strobe, a read strobe and an 8-bit data bus. Every host-side input is brought into the configuration clock domain through a chain of synchroniser flops. A selected write strobe cycle captures the bus byte into a one-byte buffer. The buffer then leaves the block as a serial stream, most significant bit first, one bit per clock, with a valid flag alongside.

A selected read strobe returns a status word. The top bit reads high when the block can take another byte and low while it is still shifting. The lower bits read as all ones. The bus is split into pad-facing input, output and output-enable signals, so the tri-state driver sits in the pad ring. If a write arrives while the previous byte is still being shifted, a sticky overrun flag is set and the byte in flight is left intact.

Top module: `byte_load_port`

## Requirements
- R1: The port is selected only while cs_lo_n is 0 and cs_hi is 1. A strobe given while the port is not selected produces no serial output and leaves bus_oe at 0.
- R2: A selected write captures bus_i. The byte then appears on ser_bit MSB first, with ser_valid at 1 for exactly DATA_W consecutive clock cycles and one bit per cycle.
- R3: Each selected low-then-high cycle of wr_n loads exactly one byte, however long wr_n stays low.
- R4: During a selected read (rd_n at 0, wr_n at 1), bus_oe is 1 and bus_o[7] gives the state: 1 means ready (not shifting) and 0 means busy (shifting).
- R5: During a status read, bus_o[6:0] are all 1.
- R6: When wr_n and rd_n are both 0 while the port is selected, the write takes effect and bus_oe stays 0.
- R7: A write completed while a byte is still shifting sets overrun_err to 1, and it stays at 1 until reset. The shifted bits remain those of the first byte, and the late byte is never output.
- R8: bus_oe is 0 whenever no selected read is in progress, and it returns to 0 after rd_n rises.
- R9: A synchronous active-high rst clears ser_valid, bus_oe and overrun_err, including in the middle of a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_lo_n | input | 1 | Active-low chip select (asynchronous) |
| cs_hi | input | 1 | Active-high chip select (asynchronous) |
| wr_n | input | 1 | Active-low write strobe (asynchronous) |
| rd_n | input | 1 | Active-low read strobe (asynchronous) |
| bus_i | input | DATA_W | Data bus from the pad |
| bus_o | output | DATA_W | Status word toward the pad |
| bus_oe | output | 1 | Pad output enable; 1 drives bus_o |
| ser_bit | output | 1 | Serial data, MSB first |
| ser_valid | output | 1 | High while ser_bit carries a buffered bit |
| overrun_err | output | 1 | Sticky flag: write arrived while busy |

## Verification
The bench builds the block with its default values: DATA_W of 8 and SYNC_STAGES of 2. With these values the status bit sits on bus bit 7, a shift lasts eight cycles, and a second strobe can be placed inside that shift window to reach overrun. The bench changes strobes only on the falling clock edge and watches the serial stream continuously. Because it counts emitted bits rather than relying on fixed cycle offsets, it can also confirm that a long write strobe, an unselected strobe or a late write adds no bits.

// File: rtl/bport_pkg.sv
package bport_pkg;
  // Status word: ready flag on the top bit, all lower bits forced high.
  function automatic logic [15:0] status_word(input logic busy, input int unsigned w);
    logic [15:0] s;
    s = '1;
    s[w-1] = ~busy;
    return s;
  endfunction
endpackage

// File: rtl/bport_sync.sv
module bport_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= IDLE;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bport_shifter.sv
module bport_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  output logic              busy,
  output logic              ser_bit
);
  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
    end else if (busy) begin
      shreg <= shreg << 1;
      cnt   <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end else if (load) begin
      shreg <= load_byte;
      cnt   <= '0;
      busy  <= 1'b1;
    end
  end

  assign ser_bit = shreg[DATA_W-1];

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == LAST) |=> !busy); // R2
  AST_SHIFT_INTACT: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST) |=> (busy && shreg == ($past(shreg) << 1))); // R7
endmodule

// File: rtl/bport_wrctl.sv
module bport_wrctl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_s,
  input  logic              wr_low_s,
  input  logic [DATA_W-1:0] data_s,
  input  logic              busy,
  output logic              load,
  output logic [DATA_W-1:0] held,
  output logic              overrun
);
  logic armed, wr_low_d, done;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      wr_low_d <= 1'b0;
      held     <= '0;
    end else begin
      wr_low_d <= wr_low_s;
      if (wr_low_s && sel_s) begin
        armed <= 1'b1;
        held  <= data_s;
      end else if (!wr_low_s) begin
        armed <= 1'b0;
      end
    end
  end

  assign done = armed && wr_low_d && !wr_low_s;
  assign load = done && !busy;

  always_ff @(posedge clk) begin
    if (rst) overrun <= 1'b0;
    else if (done && busy) overrun <= 1'b1;
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R7
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> !load); // R3
endmodule

// File: rtl/byte_load_port.sv
module byte_load_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_lo_n,
  input  logic              cs_hi,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe,
  output logic              ser_bit,
  output logic              ser_valid,
  output logic              overrun_err
);
  import bport_pkg::*;

  localparam int SW = DATA_W + 4;
  localparam logic [SW-1:0] IDLE = {{DATA_W{1'b0}}, 4'b1011};

  logic [SW-1:0]     raw, syn;
  logic              sel_s, wr_low_s, rd_low_s;
  logic [DATA_W-1:0] data_s, held;
  logic              load, busy, ovr;
  logic [15:0]       sw;

  assign raw = {bus_i, cs_lo_n, cs_hi, wr_n, rd_n};

  bport_sync #(.W(SW), .STAGES(SYNC_STAGES), .IDLE(IDLE)) sync_i (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  assign sel_s    = !syn[3] && syn[2];
  assign wr_low_s = !syn[1];
  assign rd_low_s = !syn[0];
  assign data_s   = syn[SW-1:4];

  bport_wrctl #(.DATA_W(DATA_W)) wrctl_i (
    .clk(clk), .rst(rst), .sel_s(sel_s), .wr_low_s(wr_low_s),
    .data_s(data_s), .busy(busy), .load(load), .held(held), .overrun(ovr)
  );

  bport_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst(rst), .load(load), .load_byte(held),
    .busy(busy), .ser_bit(ser_bit)
  );

  assign sw = status_word(busy, DATA_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe <= 1'b0;
      bus_o  <= '1;
    end else begin
      bus_oe <= sel_s && rd_low_s && !wr_low_s;
      bus_o  <= sw[DATA_W-1:0];
    end
  end

  assign ser_valid   = busy;
  assign overrun_err = ovr;

  AST_OE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !$past(wr_low_s)); // R6
  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(sel_s)); // R1
  AST_STATUS_FILL: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (&bus_o[DATA_W-2:0])); // R5
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    load |=> ser_valid); // R2
endmodule

// File: tb/byte_load_port_tb.sv
module byte_load_port_tb_top;
  localparam int PERIOD = 10;

  logic clk = 0, rst = 1;
  logic cs_lo_n = 1, cs_hi = 0, wr_n = 1, rd_n = 1;
  logic [7:0] bus_i = 0, bus_o;
  logic bus_oe, ser_bit, ser_valid, overrun_err;

  int checks = 0, errors = 0;
  int nbits = 0;
  logic [7:0] got = 0;

  always #(PERIOD/2) clk = ~clk;

  byte_load_port dut_i (
    .clk(clk), .rst(rst), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
    .wr_n(wr_n), .rd_n(rd_n), .bus_i(bus_i), .bus_o(bus_o),
    .bus_oe(bus_oe), .ser_bit(ser_bit), .ser_valid(ser_valid),
    .overrun_err(overrun_err)
  );

  always @(negedge clk) if (ser_valid) begin
    got = {got[6:0], ser_bit};
    nbits = nbits + 1;
  end

  localparam logic [7:0] VEC [6] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h5A};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] b, input int low, input logic c0n, input logic c1);
    cs_lo_n = c0n; cs_hi = c1; bus_i = b; wr_n = 0;
    cyc(low);
    wr_n = 1;
    cyc(3);
    cs_lo_n = 1; cs_hi = 0;
  endtask

  task automatic read(output logic oe, output logic [7:0] v, input logic c0n, input logic c1);
    cs_lo_n = c0n; cs_hi = c1; rd_n = 0;
    cyc(5);
    oe = bus_oe; v = bus_o;
    rd_n = 1;
    cyc(4);
    cs_lo_n = 1; cs_hi = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic oe; logic [7:0] v; int n0; logic saw_busy;
    cyc(3); rst = 0; cyc(2);
    // R9 reset state
    chk("R9 ser_valid", ser_valid, 0);
    chk("R9 bus_oe", bus_oe, 0);
    chk("R9 overrun", overrun_err, 0);

    // R2 table-driven serialisation
    foreach (VEC[i]) begin
      n0 = nbits;
      write(VEC[i], 3, 0, 1);
      cyc(20);
      chk("R2 bit count", nbits - n0, 8);
      chk("R2 byte", got, VEC[i]);
    end

    // R4 R5 ready status
    read(oe, v, 0, 1);
    chk("R4 oe", oe, 1);
    chk("R4 ready", v[7], 1);
    chk("R5 low bits", v[6:0], 7'h7F);
    chk("R8 oe after read", bus_oe, 0);

    // R4 busy status: read held low across a write
    saw_busy = 0;
    cs_lo_n = 0; cs_hi = 1; rd_n = 0; bus_i = 8'h66;
    cyc(5); wr_n = 0; cyc(3); wr_n = 1;
    repeat (12) begin
      @(negedge clk);
      if (bus_oe && !bus_o[7]) saw_busy = 1;
    end
    chk("R4 busy seen", saw_busy, 1);
    cyc(10);
    chk("R4 ready again", bus_o[7], 1);
    rd_n = 1; cyc(4); cs_lo_n = 1; cs_hi = 0; cyc(2);

    // R1 unselected strobes ignored
    n0 = nbits;
    write(8'h11, 3, 1, 1); cyc(15);
    write(8'h22, 3, 0, 0); cyc(15);
    chk("R1 no bits", nbits - n0, 0);
    read(oe, v, 1, 0);
    chk("R1 no drive", oe, 0);

    // R3 long strobe loads once
    n0 = nbits;
    write(8'hC3, 15, 0, 1); cyc(20);
    chk("R3 bit count", nbits - n0, 8);
    chk("R3 byte", got, 8'hC3);

    // R6 both strobes low
    n0 = nbits;
    cs_lo_n = 0; cs_hi = 1; bus_i = 8'h96; rd_n = 0; wr_n = 0;
    cyc(5);
    chk("R6 no drive", bus_oe, 0);
    wr_n = 1; rd_n = 1; cyc(3); cs_lo_n = 1; cs_hi = 0; cyc(20);
    chk("R6 write taken", got, 8'h96);
    chk("R6 bit count", nbits - n0, 8);

    // R7 overrun
    n0 = nbits;
    chk("R7 clear before", overrun_err, 0);
    cs_lo_n = 0; cs_hi = 1; bus_i = 8'hB4; wr_n = 0; cyc(3);
    wr_n = 1; cyc(1); bus_i = 8'h4B; wr_n = 0; cyc(2);
    wr_n = 1; cyc(3); cs_lo_n = 1; cs_hi = 0; cyc(25);
    chk("R7 overrun", overrun_err, 1);
    chk("R7 first byte kept", got, 8'hB4);
    chk("R7 late byte dropped", nbits - n0, 8);

    // R9 reset mid-shift
    write(8'hF0, 3, 0, 1);
    rst = 1; cyc(2); rst = 0; cyc(1);
    chk("R9 valid cleared", ser_valid, 0);
    chk("R9 overrun cleared", overrun_err, 0);
    chk("R8 idle oe", bus_oe, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule